// File: doc/BRIEF.md
# Debug Address Translation Walker

This block turns a virtual address into a physical address for a debug or inspection path. It leaves the replacement state of the TLBs unchanged. A start strobe carries the virtual address and a packed processor status word. The status word selects pass-through, 32-bit address masking, the real/virtual mode of each TLB, the partition and the context. In hypervisor mode the walker returns the address as it is.

Otherwise the walker queries the data TLB and then the instruction TLB, with the used-bit update held off. If both miss, it probes four translation-storage-buffer slots in a fixed order through a 64-bit read port. The slot pointers come from outside the block. It compares each slot's tag word with the upper virtual address bits. On a match it reads the page-table entry stored 8 bytes above the tag. It then merges the entry's physical frame with the page offset, using a mask set by the entry's page-size code. The result is a one-cycle `done` pulse with `paddr`, or a one-cycle `err` pulse.

Top module: `dbg_xlate_walker`

## Requirements
- R1: When `start` is taken with status bit 0 set, `done` pulses in the cycle after the start edge and `paddr` equals `vaddr` unchanged, even when status bit 3 is also set. No TLB query or memory read is issued.
- R2: When status bit 3 is set (and bit 0 clear), bits 63:32 of the address are cleared before any lookup. The cleared address appears on `tlb_va` and is used for tag compare and offset merge.
- R3: `tlb_part` carries status bits 15:8. `tlb_ctx` is 0 when status bits 18:16 are nonzero; otherwise it carries status bits 47:32.
- R4: `dtlb_real` is the inverse of status bit 5 and `itlb_real` is the inverse of status bit 4.
- R5: The data TLB is queried for exactly the cycle after the start edge. The instruction TLB is queried in the next cycle, and only after a data miss. `tlb_upd_used` is 0 whenever either query is active. At most one of `dtlb_req`, `itlb_req`, `mem_req` is high at a time.
- R6: After both TLBs miss, the tag words at pointers 0, 1, 2, 3 are read in that order. The walk stops at the first slot whose tag has bit 62 clear and bits 41:0 equal to address bits 63:22.
- R7: On a tag match, the entry word is read from that slot's pointer plus 8. Each read holds `mem_req` and `mem_addr` steady until a cycle with `mem_rvalid` high, which delivers `mem_rdata`.
- R8: The page-size code is {entry bit 48, entry bits 62:61}. Codes 0 to 5 select pages of 8 KiB, 64 KiB, 512 KiB, 4 MiB, 256 MiB and 2 GiB. The result is `paddr` = ({entry bits 39:13, 13 zero bits} & ~(page-1)) | (address & (page-1)). Entry bits 12:0 are ignored.
- R9: `err` pulses instead of `done` in three cases: all four probes miss, the selected entry has bit 63 clear, or the size code is 6 or 7.
- R10: `done` and `err` are single-cycle pulses, never high together. They rise in the cycle after the edge that consumes the deciding response. `start` is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a translation (taken only when idle) |
| vaddr | input | 64 | Virtual address to translate |
| status | input | 64 | Packed processor mode/context status word |
| tsb_ptrs | input | 256 | Four 64-bit slot pointers, pointer n in bits 64n+63:64n |
| tlb_va | output | 64 | Address presented to both TLB queries |
| tlb_part | output | 8 | Partition for TLB queries |
| tlb_ctx | output | 16 | Context for TLB queries |
| tlb_upd_used | output | 1 | Used-bit update enable for TLB queries (held 0) |
| dtlb_req | output | 1 | Data TLB query active |
| dtlb_real | output | 1 | Data TLB query is a real-address lookup |
| dtlb_hit | input | 1 | Data TLB hit, same cycle as the query |
| dtlb_pte | input | 64 | Data TLB entry on hit |
| itlb_req | output | 1 | Instruction TLB query active |
| itlb_real | output | 1 | Instruction TLB query is a real-address lookup |
| itlb_hit | input | 1 | Instruction TLB hit, same cycle as the query |
| itlb_pte | input | 64 | Instruction TLB entry on hit |
| mem_req | output | 1 | Memory read request, held until served |
| mem_addr | output | 64 | Memory read address |
| mem_rvalid | input | 1 | Read data valid this cycle |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Translation succeeded (one-cycle pulse) |
| paddr | output | 64 | Translated physical address, valid with `done` |
| err | output | 1 | Translation failed (one-cycle pulse) |

## Verification
The hardest case to reach is a walk that passes through several slots before it resolves. Here a valid tag for a different address must be skipped, a tag that matches but is marked invalid must be rejected, and the entry read must come from pointer plus 8, all under memory latency. The stimulus sets both TLB models to miss and fills a small memory image with deliberate near-miss tags. The read latency is set to 0, 1 or 2 cycles, which shifts the expected completion cycle by a known amount per read. A start pulse during a walk, with a pass-through status, checks that a busy walker ignores new requests.

// File: rtl/xw_pkg.sv
// Package: shared state encoding and decoded status fields for the walker.
// Assumes a 64-bit status word whose bit positions are fixed by the core.
package xw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DTLB,
        ST_ITLB,
        ST_TAG,
        ST_PTE
    } xw_state_e;

    typedef struct packed {
        logic        hpriv;
        logic        amask;
        logic        d_real;
        logic        i_real;
        logic [7:0]  part;
        logic [15:0] ctx;
    } xw_fields_t;

endpackage

// File: rtl/xw_status_decode.sv
// Module: splits the packed status word into the fields the walker uses.
// Assumes: hypervisor bit 0, address mask bit 3, inst-translate bit 4,
// data-translate bit 5, partition 15:8, context-zero 18:16, primary ctx 47:32.
module xw_status_decode
    import xw_pkg::*;
(
    input  logic [63:0] status,
    output xw_fields_t  fields
);
    // Decode the mode and context fields (R1 R2 R3 R4).
    always_comb begin
        fields.hpriv  = status[0];
        fields.amask  = status[3];
        fields.i_real = ~status[4];
        fields.d_real = ~status[5];
        fields.part   = status[15:8];
        fields.ctx    = (|status[18:16]) ? 16'h0 : status[47:32];
    end
endmodule

// File: rtl/xw_tag_match.sv
// Module: compares one slot tag word against the virtual address.
// Assumes: tag bit 62 set marks the slot invalid; tag bits 41:0 hold VA 63:22.
module xw_tag_match #(
    parameter int TAG_LSB = 22
) (
    input  logic [63:0] tag,
    input  logic [63:0] va,
    output logic        hit
);
    localparam int CMP_W = 64 - TAG_LSB;

    // Valid-and-equal comparison of the tag (R6).
    always_comb begin
        hit = ~tag[62] && (tag[CMP_W-1:0] == va[63:TAG_LSB]);
    end
endmodule

// File: rtl/xw_pte_merge.sv
// Module: checks an entry word and forms the physical address from it.
// Assumes: size code {48,62:61}; codes 0..5 legal; frame bits PA_MSB:13.
module xw_pte_merge #(
    parameter int PA_MSB   = 39,
    parameter int PG_SHIFT = 13
) (
    input  logic [63:0] va,
    input  logic [63:0] pte,
    output logic [63:0] pa,
    output logic        ok
);
    localparam int PAD_W = 63 - PA_MSB;

    logic [2:0]  code;
    logic [5:0]  shift;
    logic [63:0] pmask;
    logic [63:0] base;

    // Page shift per size code: 3 bits per step for the four small sizes (R8).
    function automatic logic [5:0] code_shift(input logic [2:0] c);
        case (c)
            3'd4:    return 6'd28;
            3'd5:    return 6'd31;
            default: return 6'(PG_SHIFT + 3 * int'(c[1:0]));
        endcase
    endfunction

    // Size decode, mask, merge and legality (R8 R9).
    always_comb begin
        code  = {pte[48], pte[62:61]};
        shift = code_shift(code);
        pmask = (64'd1 << shift) - 64'd1;
        base  = {{PAD_W{1'b0}}, pte[PA_MSB:PG_SHIFT], {PG_SHIFT{1'b0}}};
        pa    = (base & ~pmask) | (va & pmask);
        ok    = pte[63] && (code < 3'd6);
    end
endmodule

// File: rtl/dbg_xlate_walker.sv
// Module: sequential debug translator. Probes data TLB, instruction TLB,
// then up to PROBES slot tags in memory, without touching TLB used bits.
// Assumes: TLB responses arrive in the query cycle; memory answers with
// mem_rvalid some cycles later while the request is held.
module dbg_xlate_walker
    import xw_pkg::*;
#(
    parameter int PROBES  = 4,
    parameter int PA_MSB  = 39,
    parameter int PTE_OFS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [63:0]          vaddr,
    input  logic [63:0]          status,
    input  logic [PROBES*64-1:0] tsb_ptrs,
    output logic [63:0]          tlb_va,
    output logic [7:0]           tlb_part,
    output logic [15:0]          tlb_ctx,
    output logic                 tlb_upd_used,
    output logic                 dtlb_req,
    output logic                 dtlb_real,
    input  logic                 dtlb_hit,
    input  logic [63:0]          dtlb_pte,
    output logic                 itlb_req,
    output logic                 itlb_real,
    input  logic                 itlb_hit,
    input  logic [63:0]          itlb_pte,
    output logic                 mem_req,
    output logic [63:0]          mem_addr,
    input  logic                 mem_rvalid,
    input  logic [63:0]          mem_rdata,
    output logic                 done,
    output logic [63:0]          paddr,
    output logic                 err
);
    localparam int IDX_W = (PROBES > 1) ? $clog2(PROBES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PROBES - 1);

    xw_state_e        state;
    xw_fields_t       dec_f;
    xw_fields_t       fld_q;
    logic [63:0]      va_q;
    logic [IDX_W-1:0] idx;
    logic [63:0]      ptr_arr [PROBES];
    logic [63:0]      ptr_sel;
    logic [63:0]      pte_sel;
    logic [63:0]      m_pa;
    logic             m_ok;
    logic             tag_hit;
    logic             done_q;
    logic             err_q;
    logic [63:0]      pa_q;
    logic             st_idle;

    xw_status_decode u_dec (
        .status (status),
        .fields (dec_f)
    );

    // Unpack the slot pointer bus into one word per probe.
    for (genvar g = 0; g < PROBES; g++) begin : g_ptr
        assign ptr_arr[g] = tsb_ptrs[g*64 +: 64];
    end

    assign ptr_sel = ptr_arr[idx];

    // Entry source: the TLB being queried, else the memory read data.
    always_comb begin
        case (state)
            ST_DTLB: pte_sel = dtlb_pte;
            ST_ITLB: pte_sel = itlb_pte;
            default: pte_sel = mem_rdata;
        endcase
    end

    xw_tag_match #(.TAG_LSB(22)) u_tag (
        .tag (mem_rdata),
        .va  (va_q),
        .hit (tag_hit)
    );

    xw_pte_merge #(.PA_MSB(PA_MSB), .PG_SHIFT(13)) u_merge (
        .va  (va_q),
        .pte (pte_sel),
        .pa  (m_pa),
        .ok  (m_ok)
    );

    // Walk sequencer: accept, query TLBs, probe slots, report result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            fld_q  <= '0;
            va_q   <= '0;
            idx    <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            pa_q   <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        fld_q <= dec_f;
                        if (dec_f.hpriv) begin
                            done_q <= 1'b1;
                            pa_q   <= vaddr;
                        end else begin
                            va_q  <= dec_f.amask ? {32'h0, vaddr[31:0]} : vaddr;
                            state <= ST_DTLB;
                        end
                    end
                end
                ST_DTLB: begin
                    if (dtlb_hit) begin
                        done_q <= m_ok;
                        err_q  <= ~m_ok;
                        if (m_ok) pa_q <= m_pa;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_ITLB;
                    end
                end
                ST_ITLB: begin
                    if (itlb_hit) begin
                        done_q <= m_ok;
                        err_q  <= ~m_ok;
                        if (m_ok) pa_q <= m_pa;
                        state  <= ST_IDLE;
                    end else begin
                        idx   <= '0;
                        state <= ST_TAG;
                    end
                end
                ST_TAG: begin
                    if (mem_rvalid) begin
                        if (tag_hit) begin
                            state <= ST_PTE;
                        end else if (idx == LAST_IDX) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_PTE: begin
                    if (mem_rvalid) begin
                        done_q <= m_ok;
                        err_q  <= ~m_ok;
                        if (m_ok) pa_q <= m_pa;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive query, read and result ports from the walk state.
    always_comb begin
        st_idle      = (state == ST_IDLE);
        tlb_va       = va_q;
        tlb_part     = fld_q.part;
        tlb_ctx      = fld_q.ctx;
        tlb_upd_used = 1'b0;
        dtlb_req     = (state == ST_DTLB);
        dtlb_real    = fld_q.d_real;
        itlb_req     = (state == ST_ITLB);
        itlb_real    = fld_q.i_real;
        mem_req      = (state == ST_TAG) || (state == ST_PTE);
        mem_addr     = (state == ST_PTE) ? ptr_sel + 64'(PTE_OFS) : ptr_sel;
        done         = done_q;
        err          = err_q;
        paddr        = pa_q;
    end
endmodule

// File: rtl/xw_checker.sv
// Module: temporal properties of the walker, bound onto every instance.
// Assumes: st_idle is high exactly when the walker can accept a start.
module xw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [63:0] status,
    input logic [63:0] vaddr,
    input logic        st_idle,
    input logic        dtlb_req,
    input logic        itlb_req,
    input logic        tlb_upd_used,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic [63:0] mem_addr,
    input logic        done,
    input logic        err,
    input logic [63:0] paddr
);
    AST_HPRIV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_idle && status[0]) |=> (done && !err && paddr == $past(vaddr))); // R1
    AST_HPRIV_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_idle && status[0]) |=> (!dtlb_req && !itlb_req && !mem_req)); // R1
    AST_USED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (dtlb_req || itlb_req) |-> !tlb_upd_used); // R5
    AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(itlb_req) |-> $past(dtlb_req)); // R5
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dtlb_req, itlb_req, mem_req})); // R5
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R7
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R10
    AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> ($past(!st_idle) || $past(start))); // R10
endmodule

bind dbg_xlate_walker xw_checker u_xw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .status       (status),
    .vaddr        (vaddr),
    .st_idle      (st_idle),
    .dtlb_req     (dtlb_req),
    .itlb_req     (itlb_req),
    .tlb_upd_used (tlb_upd_used),
    .mem_req      (mem_req),
    .mem_rvalid   (mem_rvalid),
    .mem_addr     (mem_addr),
    .done         (done),
    .err          (err),
    .paddr        (paddr)
);

// File: tb/dbg_xlate_walker_bench.sv
`timescale 1ns/1ps
module dbg_xlate_walker_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  vaddr = '0;
    logic [63:0]  status = '0;
    logic [255:0] tsb_ptrs;
    logic [63:0]  tlb_va;
    logic [7:0]   tlb_part;
    logic [15:0]  tlb_ctx;
    logic         tlb_upd_used, dtlb_req, dtlb_real, itlb_req, itlb_real;
    logic         dtlb_hit, itlb_hit;
    logic [63:0]  dtlb_pte, itlb_pte;
    logic         mem_req, mem_rvalid;
    logic [63:0]  mem_addr, mem_rdata;
    logic         done, err;
    logic [63:0]  paddr;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] P0 = 64'h1000, P1 = 64'h2000, P2 = 64'h3000, P3 = 64'h4000;
    localparam logic [63:0] UNSET = 64'h4000_0000_0000_0000; // tag with invalid bit

    assign tsb_ptrs = {P3, P2, P1, P0};

    always #10 clk = ~clk; // 50 MHz

    // Behavioural TLB models: one entry each, hit on matching 8 KiB page.
    logic        dt_on = 1'b0, it_on = 1'b0;
    logic [50:0] dt_vpn = '0, it_vpn = '0;
    logic [63:0] dt_pte = '0, it_pte = '0;
    always_comb begin
        dtlb_hit = dtlb_req && dt_on && (tlb_va[63:13] == dt_vpn);
        itlb_hit = itlb_req && it_on && (tlb_va[63:13] == it_vpn);
        dtlb_pte = dt_pte;
        itlb_pte = it_pte;
    end

    // Behavioural memory: small address/data image with a fixed latency.
    logic [63:0] img_a [8];
    logic [63:0] img_d [8];
    logic        img_v [8];
    int          mem_lat = 0;
    int          lat_cnt = 0;
    always_comb begin
        mem_rvalid = mem_req && (lat_cnt == mem_lat);
        mem_rdata  = UNSET;
        for (int i = 0; i < 8; i++)
            if (img_v[i] && img_a[i] == mem_addr) mem_rdata = img_d[i];
    end
    always_ff @(posedge clk) begin
        if (mem_req && !mem_rvalid) lat_cnt <= lat_cnt + 1;
        else lat_cnt <= 0;
    end

    dbg_xlate_walker u_dbg_xlate_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .status(status),
        .tsb_ptrs(tsb_ptrs), .tlb_va(tlb_va), .tlb_part(tlb_part), .tlb_ctx(tlb_ctx),
        .tlb_upd_used(tlb_upd_used), .dtlb_req(dtlb_req), .dtlb_real(dtlb_real),
        .dtlb_hit(dtlb_hit), .dtlb_pte(dtlb_pte), .itlb_req(itlb_req),
        .itlb_real(itlb_real), .itlb_hit(itlb_hit), .itlb_pte(itlb_pte),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .paddr(paddr), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(input bit v, input int code, input logic [63:0] pa);
        logic [63:0] r = '0;
        r[63]    = v;
        r[62:61] = 2'(code);
        r[48]    = code[2];
        r[39:13] = pa[39:13];
        r[12:0]  = 13'h1abc; // ignored low bits
        return r;
    endfunction

    function automatic logic [63:0] mk_tag(input bit invalid, input logic [63:0] va);
        logic [63:0] r = '0;
        r[62]   = invalid;
        r[41:0] = va[63:22];
        return r;
    endfunction

    // Reference merge from the page-size table (R8).
    function automatic logic [63:0] ref_pa(input logic [63:0] va, input logic [63:0] pte);
        logic [63:0] bytes;
        logic [63:0] base;
        case ({pte[48], pte[62:61]})
            3'd0: bytes = 64'd8192;
            3'd1: bytes = 64'd65536;
            3'd2: bytes = 64'd524288;
            3'd3: bytes = 64'd4194304;
            3'd4: bytes = 64'd268435456;
            default: bytes = 64'd2147483648;
        endcase
        base = {24'h0, pte[39:13], 13'h0};
        return (base & ~(bytes - 1)) | (va & (bytes - 1));
    endfunction

    task automatic mem_clear();
        for (int i = 0; i < 8; i++) begin img_v[i] = 1'b0; img_a[i] = '0; img_d[i] = '0; end
    endtask

    task automatic mem_put(input int i, input logic [63:0] a, input logic [63:0] d);
        img_v[i] = 1'b1; img_a[i] = a; img_d[i] = d;
    endtask

    // One translation, compared against the reference on every cycle.
    // path: 0 pass-through, 1 data TLB, 2 inst TLB, 3 slot walk (j = matching slot, 4 = none)
    task automatic run(input string req, input logic [63:0] va, input logic [63:0] st,
                       input int path, input int j, input int lat, input bit e_err,
                       input logic [63:0] e_pa, input int inj);
        logic [63:0] e_va;
        logic [63:0] ptrs [4];
        logic [63:0] eq [$];
        logic [63:0] gq [$];
        int ek;
        ptrs[0] = P0; ptrs[1] = P1; ptrs[2] = P2; ptrs[3] = P3;
        e_va = st[3] ? {32'h0, va[31:0]} : va;
        case (path)
            0: ek = 0;
            1: ek = 1;
            2: ek = 2;
            default: ek = (j < 4) ? 2 + (j + 2) * (lat + 1) : 2 + 4 * (lat + 1);
        endcase
        if (path == 3) begin
            for (int p = 0; p < 4 && p <= j; p++) eq.push_back(ptrs[p]);
            if (j < 4) eq.push_back(ptrs[j] + 64'd8);
        end
        mem_lat = lat;
        @(negedge clk);
        vaddr = va; status = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= ek + 3; k++) begin
            bit e_done = (k == ek) && !e_err;
            bit e_fail = (k == ek) && e_err;
            chk(done == e_done, req, $sformatf("done cycle %0d", k), 64'(done), 64'(e_done));
            chk(err == e_fail, "R9/R10", $sformatf("err cycle %0d", k), 64'(err), 64'(e_fail));
            chk(dtlb_req == (path != 0 && k == 0), "R5", "dtlb_req", 64'(dtlb_req), 64'(path != 0 && k == 0));
            chk(itlb_req == (path >= 2 && k == 1), "R5", "itlb_req", 64'(itlb_req), 64'(path >= 2 && k == 1));
            chk(mem_req == (path == 3 && k >= 2 && k < ek), "R7", "mem_req",
                64'(mem_req), 64'(path == 3 && k >= 2 && k < ek));
            if (e_done) chk(paddr == e_pa, req, "paddr", paddr, e_pa);
            if (dtlb_req || itlb_req) begin
                chk(tlb_va == e_va, "R2", "tlb_va", tlb_va, e_va);
                chk(tlb_part == st[15:8], "R3", "tlb_part", 64'(tlb_part), 64'(st[15:8]));
                chk(tlb_ctx == ((|st[18:16]) ? 16'h0 : st[47:32]), "R3", "tlb_ctx",
                    64'(tlb_ctx), 64'((|st[18:16]) ? 16'h0 : st[47:32]));
                chk(dtlb_real == !st[5], "R4", "dtlb_real", 64'(dtlb_real), 64'(!st[5]));
                chk(itlb_real == !st[4], "R4", "itlb_real", 64'(itlb_real), 64'(!st[4]));
                chk(tlb_upd_used == 1'b0, "R5", "tlb_upd_used", 64'(tlb_upd_used), 64'h0);
            end
            if (mem_req && mem_rvalid) gq.push_back(mem_addr);
            if (k == inj) begin start = 1'b1; status = 64'h1; vaddr = ~va; end
            else start = 1'b0;
            @(negedge clk);
        end
        chk(gq.size() == eq.size(), "R6", "read count", 64'(gq.size()), 64'(eq.size()));
        for (int i = 0; i < eq.size() && i < gq.size(); i++)
            chk(gq[i] == eq[i], "R6/R7", $sformatf("read %0d address", i), gq[i], eq[i]);
        dt_on = 1'b0; it_on = 1'b0;
        mem_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] va, pte, st, mva;
        mem_clear();
        repeat (3) @(negedge clk);
        // Reset state: outputs quiet (R10)
        chk(!done && !err, "R10", "reset done/err", {62'h0, done, err}, 64'h0);
        chk(!dtlb_req && !itlb_req && !mem_req, "R5", "reset requests",
            {61'h0, dtlb_req, itlb_req, mem_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: pass-through, mask bit ignored
        va = 64'hffff_1234_5678_9abc;
        run("R1", va, 64'h9, 0, 0, 0, 1'b0, va, -1);

        // R3 R4 R8: data TLB hit, context forced to zero, 8 KiB page
        va  = 64'h0000_1234_5678_a123;
        pte = mk_pte(1'b1, 0, 64'h00ab_cdef_e000);
        dt_on = 1'b1; dt_vpn = va[63:13]; dt_pte = pte;
        st = (64'h1234 << 32) | (64'h1 << 16) | (64'h5a << 8) | (64'h1 << 5);
        run("R8", va, st, 1, 0, 0, 1'b0, ref_pa(va, pte), -1);

        // R2 R3 R5: masked address, inst TLB hit after data miss, 4 MiB page
        va  = 64'hdead_beef_0040_1234;
        mva = {32'h0, va[31:0]};
        pte = mk_pte(1'b1, 3, 64'h0055_5555_5000);
        it_on = 1'b1; it_vpn = mva[63:13]; it_pte = pte;
        st = (64'hbeef << 32) | (64'h77 << 8) | (64'h1 << 4) | (64'h1 << 3);
        run("R2", va, st, 2, 0, 0, 1'b0, ref_pa(mva, pte), -1);

        // R8: further size codes through the data TLB (64 KiB, 512 KiB, 256 MiB)
        for (int c = 1; c <= 4; c++) begin
            if (c == 3) continue;
            va  = 64'h0000_0000_7fff_fff8 + 64'(c);
            pte = mk_pte(1'b1, c, 64'h00f0_f0f0_e000);
            dt_on = 1'b1; dt_vpn = va[63:13]; dt_pte = pte;
            run("R8", va, 64'h0, 1, 0, 0, 1'b0, ref_pa(va, pte), -1);
        end

        // R6 R7 R8: slot 2 matches after a foreign tag and an empty slot, latency 2, 2 GiB page
        va  = 64'h0000_0123_4567_89ab;
        pte = mk_pte(1'b1, 5, 64'h00c0_0000_0000);
        mem_put(0, P0, mk_tag(1'b0, va + (64'h1 << 22)));
        mem_put(1, P2, mk_tag(1'b0, va));
        mem_put(2, P2 + 64'd8, pte);
        run("R6", va, 64'h20, 3, 2, 2, 1'b0, ref_pa(va, pte), -1);

        // R9: every slot misses; slot 1 tag equal but marked invalid
        va = 64'h0000_0456_0000_0000;
        mem_put(0, P1, mk_tag(1'b1, va));
        run("R9", va, 64'h0, 3, 4, 0, 1'b1, 64'h0, -1);

        // R9: slot 0 matches, entry valid bit clear
        va = 64'h0000_0789_0000_2000;
        mem_put(0, P0, mk_tag(1'b0, va));
        mem_put(1, P0 + 64'd8, mk_pte(1'b0, 0, 64'h0000_1000_0000));
        run("R9", va, 64'h0, 3, 0, 1, 1'b1, 64'h0, -1);

        // R9: illegal size codes 6 and 7 through the data TLB
        for (int c = 6; c <= 7; c++) begin
            va = 64'h0000_0000_0001_0000;
            dt_on = 1'b1; dt_vpn = va[63:13]; dt_pte = mk_pte(1'b1, c, 64'h0000_2000_0000);
            run("R9", va, 64'h0, 1, 0, 0, 1'b1, 64'h0, -1);
        end

        // R10: start pulsed (pass-through status) during a slot walk is ignored
        va  = 64'h0000_0abc_0000_6000;
        pte = mk_pte(1'b1, 1, 64'h0033_3333_0000);
        mem_put(0, P1, mk_tag(1'b0, va));
        mem_put(1, P1 + 64'd8, pte);
        run("R10", va, 64'h0, 3, 1, 1, 1'b0, ref_pa(va, pte), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule